// File: doc/BRIEF.md
# SDIO Transfer Splitting Sequencer

This block plans the command sequence that moves one data frame of any byte length to an SDIO card. Given the frame length and a programmable block size, it works out how many whole blocks the frame holds and how many bytes are left over. It then issues a block-mode extended I/O read/write (CMD53) descriptor for the whole blocks, followed by one or more byte-mode CMD53 descriptors for the tail. For example, a 544-byte frame with 64-byte blocks becomes 8 blocks at offset 0, then 32 bytes at offset 512.

Each descriptor carries a mode bit, a count and a byte offset into the frame. It is held on the outputs until the command engine downstream pulses `cmd_done_i`. The sequencer does not drive the card, compute CRCs or move any data. The whole-block count comes from a serial restoring divider, so any block size from 1 to the maximum is handled without a hardware multiplier or a full divider.

Top module: `sdio_split_seq`

## Requirements
- R1: `start_i` is taken only while `busy_o` is low, and `busy_o` is high in the cycle after an accepted start. A start pulse while busy is ignored, along with the length that comes with it.
- R2: When the length is a non-zero multiple of a valid block size, exactly one descriptor is issued: `cmd_mode_o`=1 (block), `cmd_count_o` = length / block size, `cmd_offset_o` = 0.
- R3: When the length is at least one block and not a multiple of it, the block-mode descriptor comes first. It is followed by byte-mode descriptors (`cmd_mode_o`=0) starting at offset = block count × block size, whose counts add up to the remainder.
- R4: When the length is non-zero and below one valid block, only byte-mode descriptors are issued, starting at offset 0.
- R5: A byte-mode descriptor never counts more than BYTE_MAX (512) bytes or zero bytes. A longer tail is cut into BYTE_MAX pieces followed by one shorter piece, each at the offset where the previous one ended.
- R6: While `cmd_valid_o` is high and `cmd_done_i` is low, the mode, count and offset stay unchanged. The next descriptor appears only after `cmd_done_i`, and `cmd_done_i` has no effect while `cmd_valid_o` is low.
- R7: A zero-length request issues no descriptor and raises `done_o` in the cycle after the start.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last descriptor is acknowledged. `cmd_valid_o` is low during that cycle, and `busy_o` is low in the cycle after it.
- R9: A block size of 0 or above BLK_MAX (2048) sends the whole frame as byte-mode descriptors from offset 0.
- R10: After reset, `cmd_valid_o`, `busy_o` and `done_o` are low.
- R11: A 544-byte frame with 64-byte blocks yields a block descriptor of 8 at offset 0, then a byte descriptor of 32 at offset 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| frame_len_i | input | LEN_W | Frame length in bytes, sampled at start |
| blk_size_i | input | $clog2(BLK_MAX)+1 | Block size in bytes, sampled at start |
| cmd_done_i | input | 1 | Downstream acknowledge of the current descriptor |
| cmd_valid_o | output | 1 | Descriptor present |
| cmd_mode_o | output | 1 | 1 = block mode, 0 = byte mode |
| cmd_count_o | output | LEN_W | Block count (block mode) or byte count (byte mode) |
| cmd_offset_o | output | LEN_W | Byte offset of the first byte in the frame |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the gap while the serial divider is still running. During that gap the sequencer is busy but shows no descriptor, so both a second start and a stray acknowledge could corrupt it. The stimulus reaches this gap by raising `start_i` with a different length and pulsing `cmd_done_i` in the first cycle after an accepted start. It then checks that the descriptors that follow still match the original frame. Long tails that need several byte-mode pieces come from a block size near the maximum, and the out-of-range block size path is driven with 0 and with 3000.

// File: rtl/sdio_split_pkg.sv
package sdio_split_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV,
        ST_BLK,
        ST_BYT,
        ST_FIN
    } split_state_e;

    localparam logic MODE_BYTE  = 1'b0;
    localparam logic MODE_BLOCK = 1'b1;

endpackage

// File: rtl/sdio_split_div.sv
module sdio_split_div #(
    parameter int LEN_W = 16,
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [LEN_W-1:0] dividend_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic [LEN_W-1:0] quot_o,
    output logic [LEN_W-1:0] rem_o,
    output logic             done_o
);
    localparam int CW = (LEN_W > 1) ? $clog2(LEN_W) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(LEN_W - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [LEN_W-1:0] quo;
        logic [LEN_W:0]   rem;
        logic [DIV_W-1:0] dvs;
    } div_t;

    div_t q, d;
    logic [LEN_W:0] trial;
    logic [LEN_W:0] dvs_ext;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        trial   = {q.rem[LEN_W-1:0], q.quo[LEN_W-1]};
        dvs_ext = {{(LEN_W + 1 - DIV_W){1'b0}}, q.dvs};
        if (go_i) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.quo  = dividend_i;
            d.rem  = '0;
            d.dvs  = divisor_i;
        end else if (q.busy) begin
            if (trial >= dvs_ext) begin
                d.rem = trial - dvs_ext;
                d.quo = {q.quo[LEN_W-2:0], 1'b1};
            end else begin
                d.rem = trial;
                d.quo = {q.quo[LEN_W-2:0], 1'b0};
            end
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_LAST) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quot_o = q.quo;
    assign rem_o  = q.rem[LEN_W-1:0];
    assign done_o = q.done;

endmodule

// File: rtl/sdio_split_ctrl.sv
module sdio_split_ctrl
    import sdio_split_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int BLK_W    = 12,
    parameter int BLK_MAX  = 2048,
    parameter int BYTE_MAX = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] frame_len_i,
    input  logic [BLK_W-1:0] blk_size_i,
    input  logic             cmd_done_i,
    input  logic             div_done_i,
    input  logic [LEN_W-1:0] div_quot_i,
    input  logic [LEN_W-1:0] div_rem_i,
    output logic             div_go_o,
    output logic             cmd_valid_o,
    output logic             cmd_mode_o,
    output logic [LEN_W-1:0] cmd_count_o,
    output logic [LEN_W-1:0] cmd_offset_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [LEN_W-1:0] PIECE_MAX = LEN_W'(BYTE_MAX);
    localparam logic [BLK_W-1:0] BLK_LIMIT = BLK_W'(BLK_MAX);

    typedef struct packed {
        split_state_e     st;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] nblk;
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] offs;
    } ctrl_t;

    ctrl_t q, d;
    logic             blk_ok;
    logic             take;
    logic [LEN_W-1:0] piece;

    assign blk_ok = (blk_size_i != '0) && (blk_size_i <= BLK_LIMIT);
    assign take   = (q.st == ST_IDLE) && start_i;
    assign piece  = (q.left > PIECE_MAX) ? PIECE_MAX : q.left;

    always_comb begin
        d        = q;
        div_go_o = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (take) begin
                    d.len  = frame_len_i;
                    d.nblk = '0;
                    d.offs = '0;
                    d.left = frame_len_i;
                    if (frame_len_i == '0) begin
                        d.st = ST_FIN;
                    end else if (!blk_ok) begin
                        d.st = ST_BYT;
                    end else begin
                        div_go_o = 1'b1;
                        d.st     = ST_DIV;
                    end
                end
            end
            ST_DIV: begin
                if (div_done_i) begin
                    d.nblk = div_quot_i;
                    d.left = div_rem_i;
                    d.offs = q.len - div_rem_i;
                    d.st   = (div_quot_i != '0) ? ST_BLK : ST_BYT;
                end
            end
            ST_BLK: begin
                if (cmd_done_i) begin
                    d.st = (q.left != '0) ? ST_BYT : ST_FIN;
                end
            end
            ST_BYT: begin
                if (cmd_done_i) begin
                    d.left = q.left - piece;
                    d.offs = q.offs + piece;
                    if (q.left == piece) d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cmd_valid_o  = (q.st == ST_BLK) || (q.st == ST_BYT);
    assign cmd_mode_o   = (q.st == ST_BLK) ? MODE_BLOCK : MODE_BYTE;
    assign cmd_count_o  = (q.st == ST_BLK) ? q.nblk : piece;
    assign cmd_offset_o = (q.st == ST_BLK) ? '0 : q.offs;
    assign busy_o       = (q.st != ST_IDLE);
    assign done_o       = (q.st == ST_FIN);

endmodule

// File: rtl/sdio_split_seq.sv
module sdio_split_seq #(
    parameter int LEN_W    = 16,
    parameter int BLK_MAX  = 2048,
    parameter int BYTE_MAX = 512,
    localparam int BLK_W   = $clog2(BLK_MAX) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] frame_len_i,
    input  logic [BLK_W-1:0] blk_size_i,
    input  logic             cmd_done_i,
    output logic             cmd_valid_o,
    output logic             cmd_mode_o,
    output logic [LEN_W-1:0] cmd_count_o,
    output logic [LEN_W-1:0] cmd_offset_o,
    output logic             busy_o,
    output logic             done_o
);
    logic             div_go;
    logic             div_done;
    logic [LEN_W-1:0] div_quot;
    logic [LEN_W-1:0] div_rem;

    sdio_split_div #(
        .LEN_W (LEN_W),
        .DIV_W (BLK_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (div_go),
        .dividend_i (frame_len_i),
        .divisor_i  (blk_size_i),
        .quot_o     (div_quot),
        .rem_o      (div_rem),
        .done_o     (div_done)
    );

    sdio_split_ctrl #(
        .LEN_W    (LEN_W),
        .BLK_W    (BLK_W),
        .BLK_MAX  (BLK_MAX),
        .BYTE_MAX (BYTE_MAX)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .frame_len_i  (frame_len_i),
        .blk_size_i   (blk_size_i),
        .cmd_done_i   (cmd_done_i),
        .div_done_i   (div_done),
        .div_quot_i   (div_quot),
        .div_rem_i    (div_rem),
        .div_go_o     (div_go),
        .cmd_valid_o  (cmd_valid_o),
        .cmd_mode_o   (cmd_mode_o),
        .cmd_count_o  (cmd_count_o),
        .cmd_offset_o (cmd_offset_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

endmodule

// File: rtl/sdio_split_seq_chk.sv
module sdio_split_seq_chk #(
    parameter int LEN_W    = 16,
    parameter int BYTE_MAX = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             cmd_done_i,
    input logic             cmd_valid_o,
    input logic             cmd_mode_o,
    input logic [LEN_W-1:0] cmd_count_o,
    input logic [LEN_W-1:0] cmd_offset_o,
    input logic             busy_o,
    input logic             done_o
);
    localparam logic [LEN_W-1:0] PIECE_MAX = LEN_W'(BYTE_MAX);

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_block_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_mode_o) |-> (cmd_count_o != '0 && cmd_offset_o == '0));

    p_piece_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_mode_o) |-> (cmd_count_o != '0 && cmd_count_o <= PIECE_MAX));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_done_i) |=>
            (cmd_valid_o && $stable(cmd_mode_o) && $stable(cmd_count_o) && $stable(cmd_offset_o)));

    p_no_byte_to_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_mode_o) |=> !(cmd_valid_o && cmd_mode_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cmd_valid_o && busy_o));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cmd_valid_o && !done_o));

endmodule

bind sdio_split_seq sdio_split_seq_chk #(
    .LEN_W    (LEN_W),
    .BYTE_MAX (BYTE_MAX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cmd_done_i   (cmd_done_i),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_mode_o   (cmd_mode_o),
    .cmd_count_o  (cmd_count_o),
    .cmd_offset_o (cmd_offset_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/sdio_split_seq_tb.sv
`timescale 1ns/1ps
module sdio_split_seq_tb;
    localparam int LEN_W    = 16;
    localparam int BLK_MAX  = 2048;
    localparam int BYTE_MAX = 512;
    localparam int BLK_W    = $clog2(BLK_MAX) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] frame_len_i = '0;
    logic [BLK_W-1:0] blk_size_i = '0;
    logic             cmd_done_i = 1'b0;
    logic             cmd_valid_o;
    logic             cmd_mode_o;
    logic [LEN_W-1:0] cmd_count_o;
    logic [LEN_W-1:0] cmd_offset_o;
    logic             busy_o;
    logic             done_o;

    int n_chk  = 0;
    int n_fail = 0;

    int em [256];
    int ec [256];
    int eo [256];
    int en;

    always #5 clk = ~clk;

    sdio_split_seq #(
        .LEN_W    (LEN_W),
        .BLK_MAX  (BLK_MAX),
        .BYTE_MAX (BYTE_MAX)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .frame_len_i  (frame_len_i),
        .blk_size_i   (blk_size_i),
        .cmd_done_i   (cmd_done_i),
        .cmd_valid_o  (cmd_valid_o),
        .cmd_mode_o   (cmd_mode_o),
        .cmd_count_o  (cmd_count_o),
        .cmd_offset_o (cmd_offset_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Expected descriptor list from the requirements (R2, R3, R4, R5, R9)
    task automatic plan(input int len, input int blk);
        int nb, r, off, c;
        en = 0;
        if (blk >= 1 && blk <= BLK_MAX) begin
            nb = len / blk;
            r  = len % blk;
        end else begin
            nb = 0;
            r  = len;
        end
        if (nb > 0) begin
            em[en] = 1; ec[en] = nb; eo[en] = 0; en++;
        end
        off = (nb > 0) ? nb * blk : 0;
        while (r > 0) begin
            c = (r > BYTE_MAX) ? BYTE_MAX : r;
            em[en] = 0; ec[en] = c; eo[en] = off; en++;
            off += c;
            r   -= c;
        end
    endtask

    task automatic run_frame(input string req, input int len, input int blk,
                             input int dly, input bit noise);
        int idx  = 0;
        bit seen = 1'b0;
        plan(len, blk);
        @(negedge clk);
        frame_len_i = LEN_W'(len);
        blk_size_i  = BLK_W'(blk);
        start_i     = 1'b1;
        for (int t = 0; t < 20000 && !seen; t++) begin
            @(negedge clk);
            start_i    = 1'b0;
            cmd_done_i = 1'b0;
            if (t == 0) chk(req, "R1 busy after start", int'(busy_o), 1);
            if (done_o) begin
                seen = 1'b1;
                chk(req, "R8 no cmd during done", int'(cmd_valid_o), 0);
            end else if (cmd_valid_o) begin
                if (idx < en) begin
                    chk(req, "mode", int'(cmd_mode_o), em[idx]);
                    chk(req, "count", int'(cmd_count_o), ec[idx]);
                    chk(req, "offset", int'(cmd_offset_o), eo[idx]);
                    for (int k = 0; k < dly; k++) begin
                        @(negedge clk);
                        chk(req, "R6 held count", int'(cmd_count_o), ec[idx]);
                        chk(req, "R6 held offset", int'(cmd_offset_o), eo[idx]);
                    end
                end else begin
                    chk(req, "extra descriptor", idx, en - 1);
                end
                cmd_done_i = 1'b1;
                idx++;
            end else if (noise && t == 0) begin
                // R1/R6: second start with another length and a stray ack while dividing
                start_i     = 1'b1;
                frame_len_i = LEN_W'(len + 5);
                cmd_done_i  = 1'b1;
            end
        end
        chk(req, "done seen", int'(seen), 1);
        chk(req, "descriptor total", idx, en);
        @(negedge clk);
        chk(req, "R8 done one cycle", int'(done_o), 0);
        chk(req, "R8 idle after done", int'(busy_o), 0);
    endtask

    task automatic t_reset();
        chk("R10", "valid at reset", int'(cmd_valid_o), 0);
        chk("R10", "busy at reset", int'(busy_o), 0);
        chk("R10", "done at reset", int'(done_o), 0);
    endtask

    task automatic t_idle_ack();
        // R6: ack while idle leaves nothing pending
        @(negedge clk);
        cmd_done_i = 1'b1;
        @(negedge clk);
        cmd_done_i = 1'b0;
        chk("R6", "idle ack no valid", int'(cmd_valid_o), 0);
        chk("R6", "idle ack no busy", int'(busy_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ack();
        run_frame("R11", 544, 64, 0, 1'b0);
        run_frame("R2", 512, 64, 0, 1'b0);
        run_frame("R2", 1, 1, 0, 1'b0);
        run_frame("R4", 40, 64, 0, 1'b0);
        run_frame("R7", 0, 64, 0, 1'b0);
        run_frame("R5", 3000, 2048, 0, 1'b0);
        run_frame("R3", 65535, 2048, 0, 1'b0);
        run_frame("R9", 700, 0, 0, 1'b0);
        run_frame("R9", 300, 3000, 0, 1'b0);
        run_frame("R6", 1000, 100, 3, 1'b0);
        run_frame("R1", 544, 64, 2, 1'b1);
        run_frame("R3", 2047, 2048, 1, 1'b1);
        summary();
        $finish;
    end

endmodule